// File: doc/BRIEF.md
# NAND Page Program and Block Erase Engine

This block owns the page buffer and the byte storage array of a small NAND flash model. A command sequencer in front of it decodes the flash commands and hands this engine start pulses, a page index, a column and an optional pending column offset. Data-phase bytes from the flash bus are gathered into the page buffer. A program confirm then merges the buffer into the array one byte per cycle. Because the merge is a bitwise AND, programming can only turn ones into zeros. An erase restores a whole aligned block of pages, spare bytes included, to all ones.

The page geometry is a parameter with three legal page sizes: 256, 512 and 2048 data bytes. Each page carries a spare area of one thirty-second of its data size, and the buffer and each array page hold one data-plus-spare line. After reset the engine walks the whole array and writes 0xFF, so the storage starts erased. Every accepted program or erase keeps the busy flag high for a fixed, parameterised number of cycles, and the ready flag is its inverse. The sequencer reads the array through a combinational read port addressed by page and column.

Top module: `nand_pe_engine`

## Requirements
- R1: After reset is released, busy_o stays high and ready_o low for exactly TOTAL = NUM_PAGES x LINE clock cycles, where LINE = PAGE_BYTES + PAGE_BYTES/32. Once busy_o is low, every array byte reads 0xFF.
- R2: A fill_start_i pulse empties the buffer fill count. Each following wr_i with cle_i = 0 and ale_i = 0 stores data_i at the next buffer position, starting at 0. A wr_i with cle_i or ale_i high stores nothing. Once LINE bytes have been stored, further bytes are dropped.
- R3: A prog_go_i pulse programs page page_i. It starts at column s = col_i + pending offset and covers buffer bytes k = 0 .. count-1. Each target byte becomes old AND buffer[k]. Bytes whose column s + k would reach LINE or beyond are not written, and no other byte changes.
- R4: An off_load_i pulse stores off_i as the pending offset. An accepted program uses that offset and then clears it to 0, so a later program with no new load starts at col_i.
- R5: An erase_go_i pulse writes 0xFF to every data and spare byte of the PAGES_PER_BLOCK pages in the aligned block that holds page_i. All other pages keep their contents.
- R6: A program or erase whose page_i is NUM_PAGES or more is ignored. busy_o stays low, the array is unchanged, and any pending offset is kept.
- R7: A copy_start_i pulse puts the buffer in column mode at column col_i. Each data write stores data_i at the current column and then moves the column up by one, but only while the column is below LINE. A confirm in column mode ANDs the whole LINE-byte buffer into the page from column 0. The pending offset is not applied, and it is cleared.
- R8: An accepted program or erase raises busy_o on the next cycle and holds it for exactly BUSY_CYCLES cycles. ready_o is the inverse of busy_o, and the array is written only while busy_o is high.
- R9: While busy_o is high, the following have no effect: prog_go_i, erase_go_i, fill_start_i, copy_start_i, off_load_i and data writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cle_i | input | 1 | Command phase marker; a write with it high is not data |
| ale_i | input | 1 | Address phase marker; a write with it high is not data |
| wr_i | input | 1 | Bus write strobe, one byte per cycle |
| data_i | input | 8 | Bus write data |
| fill_start_i | input | 1 | Begin sequential buffer fill |
| copy_start_i | input | 1 | Begin column-addressed buffer writes at col_i |
| prog_go_i | input | 1 | Program confirm |
| erase_go_i | input | 1 | Erase start |
| page_i | input | PW | Target page index |
| col_i | input | CW | Target column |
| off_load_i | input | 1 | Load pending column offset |
| off_i | input | CW | Pending column offset value |
| rd_page_i | input | PW | Read port page |
| rd_col_i | input | CW | Read port column |
| rd_data_o | output | 8 | Read port data; 0 for an out-of-range page or column |
| busy_o | output | 1 | Operation in progress |
| ready_o | output | 1 | Ready status bit, inverse of busy_o |

## Verification
A wrong fill counter, column register or pending offset shows up as bytes landing at shifted columns, or as bytes that should have been clipped being written. The full-array comparison after the busy window catches this. A walk that runs too long or starts at a wrong base damages a neighbouring page or block, which shows on the read port as soon as busy_o falls. A busy counter or acceptance fault shows at once as a wrong count of busy cycles. It also shows as an ignored request that still changed the array.

// File: rtl/nand_pe_pkg.sv
package nand_pe_pkg;
  typedef enum logic [1:0] {OP_IDLE, OP_INIT, OP_PROG, OP_ERASE} op_e;
  typedef enum logic [1:0] {BM_NONE, BM_FILL, BM_COPY} bmode_e;

  function automatic int spare_of(input int page_bytes);
    return page_bytes / 32;
  endfunction
endpackage

// File: rtl/nand_pe_buf.sv
module nand_pe_buf
  import nand_pe_pkg::*;
#(
  parameter int LINE = 264,
  parameter int CW   = 9,
  parameter int NW   = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          lock_i,
  input  logic          fill_start_i,
  input  logic          copy_start_i,
  input  logic [CW-1:0] copy_col_i,
  input  logic          wr_i,
  input  logic [7:0]    data_i,
  input  logic          commit_i,
  input  logic [NW-1:0] rd_idx_i,
  output logic [7:0]    rd_data_o,
  output logic [NW-1:0] cnt_o,
  output logic          copy_mode_o
);
  bmode_e        mode_q;
  logic [NW-1:0] cnt_q, col_q, wr_pos;
  logic [7:0]    byte_q [LINE];
  logic          wr_ok;

  assign wr_pos = (mode_q == BM_COPY) ? col_q : cnt_q;
  assign wr_ok  = wr_i && (((mode_q == BM_FILL) && (int'(cnt_q) < LINE)) ||
                           ((mode_q == BM_COPY) && (int'(col_q) < LINE)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= BM_NONE;
      cnt_q  <= '0;
      col_q  <= '0;
      for (int i = 0; i < LINE; i++) byte_q[i] <= 8'hFF;
    end else if (!lock_i) begin
      if (fill_start_i) begin
        mode_q <= BM_FILL;
        cnt_q  <= '0;
      end else if (copy_start_i) begin
        mode_q <= BM_COPY;
        col_q  <= NW'(copy_col_i);
      end else if (commit_i) begin
        mode_q <= BM_NONE;
      end else if (wr_ok) begin
        byte_q[wr_pos] <= data_i;
        if (mode_q == BM_FILL) cnt_q <= cnt_q + NW'(1);
        else                   col_q <= col_q + NW'(1);
      end
    end
  end

  assign rd_data_o   = (int'(rd_idx_i) < LINE) ? byte_q[rd_idx_i] : 8'hFF;
  assign cnt_o       = cnt_q;
  assign copy_mode_o = (mode_q == BM_COPY);

  AST_FILL_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(cnt_q) <= LINE);  // R2
  AST_COPY_COL_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == BM_COPY && wr_i && int'(col_q) >= LINE && !lock_i) |=> $stable(col_q));  // R7
  AST_LOCK_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_i |=> ($stable(cnt_q) && $stable(col_q) && $stable(mode_q)));  // R9
endmodule

// File: rtl/nand_pe_ctl.sv
module nand_pe_ctl
  import nand_pe_pkg::*;
#(
  parameter int LINE        = 264,
  parameter int NUM_PAGES   = 8,
  parameter int PPB         = 4,
  parameter int BUSY_CYCLES = 1100,
  parameter int PW          = 4,
  parameter int CW          = 9,
  parameter int NW          = 9,
  parameter int AW          = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          prog_go_i,
  input  logic          erase_go_i,
  input  logic [PW-1:0] page_i,
  input  logic [CW-1:0] col_i,
  input  logic          off_load_i,
  input  logic [CW-1:0] off_i,
  input  logic [NW-1:0] buf_cnt_i,
  input  logic          copy_mode_i,
  output logic          busy_o,
  output logic          commit_o,
  output logic          we_o,
  output logic [AW-1:0] waddr_o,
  output logic [NW-1:0] buf_idx_o,
  output logic          fill_ff_o
);
  localparam int BLK_LEN = LINE * PPB;
  localparam int TOTAL   = LINE * NUM_PAGES;
  localparam int RW      = $clog2(TOTAL + 1);
  localparam int BW      = $clog2(BUSY_CYCLES + 1);

  op_e           op_q;
  logic [AW-1:0] addr_q;
  logic [RW-1:0] rem_q;
  logic [NW-1:0] bidx_q;
  logic [BW-1:0] bcnt_q;
  logic [CW-1:0] off_q;
  logic          in_range, acc_prog, acc_erase;
  int            start_col, prog_len, prog_base, erase_base;

  always_comb begin
    start_col = copy_mode_i ? 0 : int'(col_i) + int'(off_q);
    if (copy_mode_i)                               prog_len = LINE;
    else if (start_col >= LINE)                    prog_len = 0;
    else if (int'(buf_cnt_i) < LINE - start_col)   prog_len = int'(buf_cnt_i);
    else                                           prog_len = LINE - start_col;
    prog_base  = int'(page_i) * LINE + start_col;
    erase_base = (int'(page_i) / PPB) * PPB * LINE;
  end

  assign busy_o    = (op_q == OP_INIT) || (bcnt_q != '0);
  assign in_range  = int'(page_i) < NUM_PAGES;
  assign acc_prog  = prog_go_i && !busy_o && in_range;
  assign acc_erase = erase_go_i && !prog_go_i && !busy_o && in_range;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q   <= OP_INIT;
      addr_q <= '0;
      rem_q  <= RW'(TOTAL);
      bidx_q <= '0;
      bcnt_q <= '0;
      off_q  <= '0;
    end else begin
      if (bcnt_q != '0) bcnt_q <= bcnt_q - BW'(1);
      if (op_q != OP_IDLE) begin
        addr_q <= addr_q + AW'(1);
        bidx_q <= bidx_q + NW'(1);
        rem_q  <= rem_q - RW'(1);
        if (rem_q == RW'(1)) op_q <= OP_IDLE;
      end
      if (off_load_i && !busy_o) off_q <= off_i;
      if (acc_prog) begin
        bcnt_q <= BW'(BUSY_CYCLES);
        off_q  <= '0;
        addr_q <= AW'(prog_base);
        bidx_q <= '0;
        rem_q  <= RW'(prog_len);
        op_q   <= (prog_len != 0) ? OP_PROG : OP_IDLE;
      end else if (acc_erase) begin
        bcnt_q <= BW'(BUSY_CYCLES);
        addr_q <= AW'(erase_base);
        bidx_q <= '0;
        rem_q  <= RW'(BLK_LEN);
        op_q   <= OP_ERASE;
      end
    end
  end

  assign commit_o  = acc_prog;
  assign we_o      = (op_q != OP_IDLE);
  assign waddr_o   = addr_q;
  assign buf_idx_o = bidx_q;
  assign fill_ff_o = (op_q != OP_PROG);

  AST_WALK_UNDER_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_q != OP_IDLE) |-> busy_o);  // R8
  AST_WADDR_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_o |-> (int'(waddr_o) < TOTAL));  // R3
  AST_BUSY_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bcnt_q == BW'(1) && op_q != OP_INIT) |=> !busy_o);  // R8
  AST_OFF_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |=> (off_q == '0));  // R4
  AST_ERASE_SPAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_q == OP_ERASE) |-> (int'(rem_q) <= BLK_LEN));  // R5
endmodule

// File: rtl/nand_pe_array.sv
module nand_pe_array #(
  parameter int TOTAL = 2112,
  parameter int AW    = 12
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [7:0]    wdata_i,
  output logic [7:0]    wq_o,
  input  logic [AW-1:0] raddr_i,
  output logic [7:0]    rdata_o
);
  logic [7:0] mem [TOTAL];

  always_ff @(posedge clk_i) begin
    if (we_i && int'(waddr_i) < TOTAL) mem[waddr_i] <= wdata_i;
  end

  assign wq_o    = (int'(waddr_i) < TOTAL) ? mem[waddr_i] : 8'hFF;
  assign rdata_o = (int'(raddr_i) < TOTAL) ? mem[raddr_i] : 8'h00;
endmodule

// File: rtl/nand_pe_engine.sv
module nand_pe_engine
  import nand_pe_pkg::*;
#(
  parameter int PAGE_BYTES      = 256,
  parameter int NUM_PAGES       = 8,
  parameter int PAGES_PER_BLOCK = 4,
  parameter int BUSY_CYCLES     = 1100,
  localparam int LINE  = PAGE_BYTES + spare_of(PAGE_BYTES),
  localparam int TOTAL = LINE * NUM_PAGES,
  localparam int AW    = $clog2(TOTAL + 1),
  localparam int PW    = $clog2(NUM_PAGES) + 1,
  localparam int CW    = $clog2(LINE),
  localparam int NW    = $clog2(LINE + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cle_i,
  input  logic          ale_i,
  input  logic          wr_i,
  input  logic [7:0]    data_i,
  input  logic          fill_start_i,
  input  logic          copy_start_i,
  input  logic          prog_go_i,
  input  logic          erase_go_i,
  input  logic [PW-1:0] page_i,
  input  logic [CW-1:0] col_i,
  input  logic          off_load_i,
  input  logic [CW-1:0] off_i,
  input  logic [PW-1:0] rd_page_i,
  input  logic [CW-1:0] rd_col_i,
  output logic [7:0]    rd_data_o,
  output logic          busy_o,
  output logic          ready_o
);
  if (!(PAGE_BYTES == 256 || PAGE_BYTES == 512 || PAGE_BYTES == 2048) ||
      (LINE * PAGES_PER_BLOCK > BUSY_CYCLES) || (LINE > BUSY_CYCLES)) begin : g_bad_cfg
    initial $error("nand_pe_engine: unsupported geometry or busy window too short");
  end

  logic          data_wr, commit, copy_mode, arr_we, fill_ff;
  logic [NW-1:0] buf_cnt, buf_idx;
  logic [7:0]    buf_byte, arr_old, arr_rd, arr_wdata;
  logic [AW-1:0] arr_waddr, rd_addr;
  logic          rd_ok;

  assign data_wr = wr_i && !cle_i && !ale_i;

  nand_pe_buf #(.LINE(LINE), .CW(CW), .NW(NW)) u_buf (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .lock_i       (busy_o),
    .fill_start_i (fill_start_i),
    .copy_start_i (copy_start_i),
    .copy_col_i   (col_i),
    .wr_i         (data_wr),
    .data_i       (data_i),
    .commit_i     (commit),
    .rd_idx_i     (buf_idx),
    .rd_data_o    (buf_byte),
    .cnt_o        (buf_cnt),
    .copy_mode_o  (copy_mode)
  );

  nand_pe_ctl #(
    .LINE(LINE), .NUM_PAGES(NUM_PAGES), .PPB(PAGES_PER_BLOCK),
    .BUSY_CYCLES(BUSY_CYCLES), .PW(PW), .CW(CW), .NW(NW), .AW(AW)
  ) u_ctl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .prog_go_i   (prog_go_i),
    .erase_go_i  (erase_go_i),
    .page_i      (page_i),
    .col_i       (col_i),
    .off_load_i  (off_load_i),
    .off_i       (off_i),
    .buf_cnt_i   (buf_cnt),
    .copy_mode_i (copy_mode),
    .busy_o      (busy_o),
    .commit_o    (commit),
    .we_o        (arr_we),
    .waddr_o     (arr_waddr),
    .buf_idx_o   (buf_idx),
    .fill_ff_o   (fill_ff)
  );

  assign arr_wdata = fill_ff ? 8'hFF : (arr_old & buf_byte);

  assign rd_ok   = (int'(rd_page_i) < NUM_PAGES) && (int'(rd_col_i) < LINE);
  assign rd_addr = AW'(int'(rd_page_i) * LINE + int'(rd_col_i));

  nand_pe_array #(.TOTAL(TOTAL), .AW(AW)) u_array (
    .clk_i   (clk_i),
    .we_i    (arr_we),
    .waddr_i (arr_waddr),
    .wdata_i (arr_wdata),
    .wq_o    (arr_old),
    .raddr_i (rd_addr),
    .rdata_o (arr_rd)
  );

  assign rd_data_o = rd_ok ? arr_rd : 8'h00;
  assign ready_o   = !busy_o;

  AST_NO_WRITE_WHEN_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> !arr_we);  // R8
  AST_NO_COMMIT_IN_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arr_we |-> !commit);  // R9
endmodule

// File: tb/tb_nand_pe_engine.sv
module tb_nand_pe_engine;
  localparam int PB    = 256;
  localparam int NP    = 8;
  localparam int PPB   = 4;
  localparam int BUSY  = 1100;
  localparam int LINE  = PB + PB / 32;
  localparam int TOTAL = LINE * NP;
  localparam int PW    = $clog2(NP) + 1;
  localparam int CW    = $clog2(LINE);

  logic clk = 1'b0, rst_n = 1'b0;
  logic cle = 0, ale = 0, wr = 0, fill_start = 0, copy_start = 0;
  logic prog_go = 0, erase_go = 0, off_load = 0;
  logic [7:0] data = 0;
  logic [PW-1:0] page = 0, rd_page = 0;
  logic [CW-1:0] col = 0, off = 0, rd_col = 0;
  logic [7:0] rd_data;
  logic busy, ready;

  always #5 clk = ~clk;

  nand_pe_engine #(.PAGE_BYTES(PB), .NUM_PAGES(NP), .PAGES_PER_BLOCK(PPB), .BUSY_CYCLES(BUSY)) dut (
    .clk_i(clk), .rst_ni(rst_n), .cle_i(cle), .ale_i(ale), .wr_i(wr), .data_i(data),
    .fill_start_i(fill_start), .copy_start_i(copy_start), .prog_go_i(prog_go),
    .erase_go_i(erase_go), .page_i(page), .col_i(col), .off_load_i(off_load), .off_i(off),
    .rd_page_i(rd_page), .rd_col_i(rd_col), .rd_data_o(rd_data), .busy_o(busy), .ready_o(ready)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  // bench model
  logic [7:0] mem_m [TOTAL];
  logic [7:0] buf_m [LINE];
  int cnt_m = 0, col_m = 0, off_m = 0, mode_m = 0;  // 0 none, 1 fill, 2 column

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic compare_all(input string tag);
    int bad = 0, fa = 0, fe = 0, fp = 0, fc = 0;
    for (int p = 0; p < NP; p++)
      for (int c = 0; c < LINE; c++) begin
        rd_page = PW'(p); rd_col = CW'(c);
        #1;
        if (rd_data !== mem_m[p*LINE+c]) begin
          if (bad == 0) begin fa = rd_data; fe = mem_m[p*LINE+c]; fp = p; fc = c; end
          bad++;
        end
      end
    chk(bad == 0, $sformatf("%s page %0d col %0d (%0d bad bytes)", tag, fp, fc, bad), fa, fe);
    @(negedge clk);
  endtask

  task automatic m_wr(input logic [7:0] d, input bit c, input bit a, input bit ign);
    wr = 1; data = d; cle = c; ale = a;
    @(negedge clk);
    wr = 0; cle = 0; ale = 0;
    if (!ign && !c && !a) begin
      if (mode_m == 1 && cnt_m < LINE) begin buf_m[cnt_m] = d; cnt_m++; end
      else if (mode_m == 2 && col_m < LINE) begin buf_m[col_m] = d; col_m++; end
    end
  endtask

  task automatic m_fill_start();
    fill_start = 1; @(negedge clk); fill_start = 0;
    mode_m = 1; cnt_m = 0;
  endtask

  task automatic m_copy_start(input int c);
    copy_start = 1; col = CW'(c); @(negedge clk); copy_start = 0;
    mode_m = 2; col_m = c;
  endtask

  task automatic m_off_load(input int o);
    off_load = 1; off = CW'(o); @(negedge clk); off_load = 0;
    off_m = o;
  endtask

  task automatic count_busy(output int n);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
  endtask

  task automatic m_prog(input int pg, input int c, input string tag);
    int n, s, len;
    prog_go = 1; page = PW'(pg); col = CW'(c);
    @(negedge clk);
    prog_go = 0;
    if (pg < NP) begin
      s = (mode_m == 2) ? 0 : c + off_m;
      if (mode_m == 2) len = LINE;
      else if (s >= LINE) len = 0;
      else len = (cnt_m < LINE - s) ? cnt_m : LINE - s;
      for (int k = 0; k < len; k++) mem_m[pg*LINE+s+k] = mem_m[pg*LINE+s+k] & buf_m[k];
      off_m = 0; mode_m = 0;
    end
    count_busy(n);
    chk(n == ((pg < NP) ? BUSY : 0), {(pg < NP) ? "R8" : "R6", " busy length ", tag}, n, (pg < NP) ? BUSY : 0);
  endtask

  task automatic m_erase(input int pg, input string tag);
    int n, b;
    erase_go = 1; page = PW'(pg);
    @(negedge clk);
    erase_go = 0;
    if (pg < NP) begin
      b = (pg / PPB) * PPB;
      for (int k = 0; k < PPB * LINE; k++) mem_m[b*LINE+k] = 8'hFF;
    end
    count_busy(n);
    chk(n == ((pg < NP) ? BUSY : 0), {(pg < NP) ? "R8" : "R6", " busy length ", tag}, n, (pg < NP) ? BUSY : 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R8 watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int n, pg, c, cnt;
    void'($urandom(32'd1234));
    for (int i = 0; i < TOTAL; i++) mem_m[i] = 8'hFF;
    for (int i = 0; i < LINE; i++) buf_m[i] = 8'hFF;

    // R1: reset and power-up clear
    repeat (3) @(negedge clk);
    chk(busy == 1'b1 && ready == 1'b0, "R1 busy in reset", busy, 1);
    rst_n = 1;
    n = 0;
    do begin @(negedge clk); n++; end while (busy && n < TOTAL + 10);
    chk(n == TOTAL, "R1 init walk length", n, TOTAL);
    chk(ready == 1'b1, "R1 ready after init", ready, 1);
    compare_all("R1 erased after init");

    // R2 R3: basic fill with cle/ale noise
    m_fill_start();
    for (int i = 0; i < 10; i++) begin
      m_wr(8'(8'hA5 ^ (i * 17)), 0, 0, 0);
      if (i == 3) m_wr(8'h00, 1, 0, 0);
      if (i == 6) m_wr(8'h00, 0, 1, 0);
    end
    m_prog(2, 5, "fill");
    compare_all("R2 R3 program with noise writes");

    // R3: AND into programmed bytes
    m_fill_start();
    for (int i = 0; i < 12; i++) m_wr(8'(8'h3C + i * 29), 0, 0, 0);
    m_prog(2, 8, "and");
    compare_all("R3 second program only clears bits");

    // R2: overflow past LINE dropped
    m_fill_start();
    for (int i = 0; i < LINE + 6; i++) m_wr(8'(i * 7 + 1), 0, 0, 0);
    m_prog(3, 0, "overflow");
    compare_all("R2 buffer overflow dropped");

    // R4: pending offset applied then cleared
    m_fill_start();
    for (int i = 0; i < 4; i++) m_wr(8'(8'h0F << i), 0, 0, 0);
    m_off_load(7);
    m_prog(4, 3, "offset");
    compare_all("R4 offset applied");
    m_fill_start();
    for (int i = 0; i < 4; i++) m_wr(8'(8'hF0 >> i), 0, 0, 0);
    m_prog(4, 3, "offset cleared");
    compare_all("R4 offset cleared after program");

    // R3: clip at end of line
    m_fill_start();
    for (int i = 0; i < 8; i++) m_wr(8'h11 * i[7:0], 0, 0, 0);
    m_prog(5, LINE - 3, "clip");
    compare_all("R3 clipped at line end");

    // R6: out-of-range program keeps offset
    m_off_load(2);
    m_fill_start();
    for (int i = 0; i < 3; i++) m_wr(8'h5A, 0, 0, 0);
    m_prog(NP, 0, "oor prog");
    compare_all("R6 out-of-range program ignored");
    m_prog(6, 1, "after oor");
    compare_all("R6 offset kept after ignored program");

    // R5: erase block, R6 out-of-range erase
    m_erase(NP + 1, "oor erase");
    compare_all("R6 out-of-range erase ignored");
    m_erase(5, "erase");
    compare_all("R5 block erase");

    // R7: column-mode writes
    m_copy_start(100);
    for (int i = 0; i < 5; i++) m_wr(8'(8'h81 + i), 0, 0, 0);
    m_copy_start(LINE - 2);
    for (int i = 0; i < 4; i++) m_wr(8'(8'h42 + i), 0, 0, 0);
    m_off_load(9);
    m_prog(1, 40, "copy");
    compare_all("R7 column mode program");

    // R9: requests during busy are ignored
    erase_go = 1; page = PW'(1);
    @(negedge clk);
    erase_go = 0;
    for (int k = 0; k < PPB * LINE; k++) mem_m[k] = 8'hFF;
    n = 0;
    while (busy) begin
      n++;
      if (n == 5) begin prog_go = 1; erase_go = 1; page = PW'(6); col = 0; fill_start = 1; off_load = 1; off = 3; end
      if (n == 6) begin prog_go = 0; erase_go = 0; fill_start = 0; off_load = 0; wr = 1; data = 8'h00; end
      if (n == 8) wr = 0;
      @(negedge clk);
    end
    chk(n == BUSY, "R9 busy not restarted", n, BUSY);
    compare_all("R9 requests ignored while busy");
    m_prog(7, 0, "after busy");
    compare_all("R9 buffer and offset untouched while busy");

    // randomized rounds
    for (int r = 0; r < 14; r++) begin
      case ($urandom % 3)
        0: begin
          m_fill_start();
          cnt = $urandom % (LINE / 3);
          for (int i = 0; i < cnt; i++) m_wr(8'($urandom), ($urandom % 9) == 0, ($urandom % 11) == 0, 0);
          if ($urandom % 3 == 0) m_off_load($urandom % 16);
          c = $urandom % LINE; pg = $urandom % (NP + 1);
          m_prog(pg, c, "rand prog");
          compare_all("R3 random program");
        end
        1: begin
          pg = $urandom % (NP + 2);
          m_erase(pg, "rand erase");
          compare_all("R5 random erase");
        end
        default: begin
          m_copy_start($urandom % (LINE + 4));
          cnt = 1 + $urandom % 20;
          for (int i = 0; i < cnt; i++) m_wr(8'($urandom), 0, 0, 0);
          pg = $urandom % NP;
          m_prog(pg, $urandom % LINE, "rand copy");
          compare_all("R7 random column program");
        end
      endcase
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule